// File: doc/BRIEF.md
# Fair-Value Quote Generator

This block turns a live view of the book, a stream of trade prints and the current net position into a two-sided quote. It takes a size-weighted price over the first few levels of both sides of the book. It adds a term from the running balance of aggressive buying against aggressive selling, and subtracts an inventory term, so that a long position pushes both prices down. The bid and ask are set around this fair value by a configured spread, snapped to the tick grid, and given a configured quantity.

The quote is registered. A one-cycle request pulse tells the downstream order path to send it. The pulse is raised when the quote first becomes live or changes, and it is raised again on every expiry of a free-running refresh timer, so resting orders do not age. Under strongly one-sided flow only the side that follows the flow is quoted. While the book is out of sync, or either best level is empty, the block does not quote. All arithmetic is signed fixed-point integer, and prices are in raw price units.

Top module: `fvq_quote_gen`

## Requirements
- R1: While reset is held, `quote_req`, `quote_live`, both prices and both quantities read zero.
- R2: The weighted mid is floor(sum of price*size over bid and ask levels 0..D-1, divided by the sum of those sizes), with level 0 the best. D is `depth_cfg`: 0 is treated as 1, and a value above LEVELS is treated as LEVELS.
- R3: A valid trade adds its quantity to a signed imbalance when `trade_buy`=1 (buyer aggressor) and subtracts it when `trade_buy`=0. The imbalance shifted arithmetically right by OFI_SHIFT is added to the fair value.
- R4: On every refresh tick the imbalance is first shifted arithmetically right by DECAY. A trade in that same cycle is added to the shifted value.
- R5: The fair value is reduced by `net_pos`*`skew_k`.
- R6: With half = `spread_cfg`>>1 and tick = 2^TICK_LOG2, the bid is fv-half rounded down to the tick grid and the ask is fv+half rounded up to the tick grid. Both are clamped to 0..2^PW-1, and both quantities equal `size_cfg`.
- R7: If the imbalance is above `flow_thr`, the ask quantity is 0. If it is below -`flow_thr`, the bid quantity is 0.
- R8: When `book_sync`=0 or either best size is 0, `quote_live` and `quote_req` are 0, both quantities are 0, and the prices hold their last value.
- R9: `quote_req` pulses in the cycle after the quote becomes live or any price or quantity changes.
- R10: While live, `quote_req` also pulses once every REFRESH cycles, even when the quote is unchanged.
- R11: Outputs reflect the inputs present at the previous clock edge. A trade reaches the prices one cycle later than that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| book_sync | input | 1 | Book is in sync with the feed |
| bid_px_i | input | LEVELS*PW | Bid prices, level 0 in the low bits |
| bid_sz_i | input | LEVELS*QW | Bid sizes |
| ask_px_i | input | LEVELS*PW | Ask prices |
| ask_sz_i | input | LEVELS*QW | Ask sizes |
| depth_cfg | input | clog2(LEVELS)+1 | Levels used by the weighted mid |
| trade_vld | input | 1 | Trade print valid |
| trade_buy | input | 1 | Aggressor side, 1 means buyer |
| trade_qty | input | QW | Trade quantity |
| net_pos | input | POSW | Signed net position |
| skew_k | input | KW | Inventory skew per unit of position |
| spread_cfg | input | PW | Full quoted spread |
| size_cfg | input | QW | Quote quantity |
| flow_thr | input | IW | Imbalance threshold for one-sided quoting |
| quote_req | output | 1 | Send-quote pulse |
| quote_live | output | 1 | Quote is valid |
| bid_px_o | output | PW | Bid price |
| ask_px_o | output | PW | Ask price |
| bid_qty_o | output | QW | Bid quantity |
| ask_qty_o | output | QW | Ask quantity |

## Verification
A trade print can land on the same edge as a refresh tick. The imbalance must then be decayed and added to in that single cycle. The bench waits until its edge counter says the next edge is a tick, drives the trade onto exactly that edge, and compares the prices two edges later with a value computed as a shift followed by an add. The same tick edge can also carry a price change. The bench checks that the two causes together produce a single pulse and not two.

// File: rtl/fvq_pkg.sv
package fvq_pkg;
  typedef enum logic [1:0] {
    SIDE_BOTH = 2'd0,
    SIDE_BID  = 2'd1,
    SIDE_ASK  = 2'd2
  } side_e;
endpackage

// File: rtl/fvq_depth_mid.sv
module fvq_depth_mid #(
  parameter int LEVELS = 4,
  parameter int PW     = 16,
  parameter int QW     = 8,
  parameter int DW     = $clog2(LEVELS) + 1
) (
  input  logic [LEVELS*PW-1:0] bid_px,
  input  logic [LEVELS*QW-1:0] bid_sz,
  input  logic [LEVELS*PW-1:0] ask_px,
  input  logic [LEVELS*QW-1:0] ask_sz,
  input  logic [DW-1:0]        depth,
  output logic [PW-1:0]        mid,
  output logic                 top_ok
);
  localparam int PQ = PW + QW;
  localparam int SW = PQ + $clog2(2*LEVELS) + 1;
  localparam int ZW = QW + $clog2(2*LEVELS) + 1;
  localparam logic [SW-1:0] PMAX = {{(SW-PW){1'b0}}, {PW{1'b1}}};

  logic [DW-1:0] dcl;
  logic [PQ-1:0] bw [LEVELS];
  logic [PQ-1:0] aw [LEVELS];
  logic [QW-1:0] bs [LEVELS];
  logic [QW-1:0] as_l [LEVELS];
  logic [SW-1:0] num, quot;
  logic [ZW-1:0] den;

  // clamp the requested depth into 1..LEVELS (R2)
  always_comb begin
    if (depth == '0)                dcl = DW'(1);
    else if (depth > DW'(LEVELS))   dcl = DW'(LEVELS);
    else                            dcl = depth;
  end

  generate
    for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
      logic use_l;
      assign use_l   = (DW'(g) < dcl);
      assign bw[g]   = use_l ? ({{QW{1'b0}}, bid_px[g*PW +: PW]} * {{PW{1'b0}}, bid_sz[g*QW +: QW]}) : '0;
      assign aw[g]   = use_l ? ({{QW{1'b0}}, ask_px[g*PW +: PW]} * {{PW{1'b0}}, ask_sz[g*QW +: QW]}) : '0;
      assign bs[g]   = use_l ? bid_sz[g*QW +: QW] : '0;
      assign as_l[g] = use_l ? ask_sz[g*QW +: QW] : '0;
    end
  endgenerate

  always_comb begin
    num = '0;
    den = '0;
    for (int i = 0; i < LEVELS; i++) begin
      num = num + {{(SW-PQ){1'b0}}, bw[i]} + {{(SW-PQ){1'b0}}, aw[i]};
      den = den + {{(ZW-QW){1'b0}}, bs[i]} + {{(ZW-QW){1'b0}}, as_l[i]};
    end
    quot = (den == '0) ? '0 : num / {{(SW-ZW){1'b0}}, den};
    mid  = (quot > PMAX) ? {PW{1'b1}} : quot[PW-1:0];
  end

  assign top_ok = (bid_sz[QW-1:0] != '0) && (ask_sz[QW-1:0] != '0);
endmodule

// File: rtl/fvq_flow.sv
module fvq_flow #(
  parameter int QW    = 8,
  parameter int IW    = 16,
  parameter int DECAY = 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 trade_vld,
  input  logic                 trade_buy,
  input  logic [QW-1:0]        trade_qty,
  output logic signed [IW-1:0] imb
);
  logic signed [IW-1:0] qty_x, delta, base, imb_nx;
  logic                 upd;

  assign qty_x = $signed({{(IW-QW){1'b0}}, trade_qty});

  always_comb begin
    delta = '0;
    if (trade_vld) delta = trade_buy ? qty_x : -qty_x;
    base   = tick ? (imb >>> DECAY) : imb;
    imb_nx = base + delta;
    upd    = trade_vld | tick;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   imb <= '0;
    else if (upd) imb <= imb_nx;
  end

  p_decay_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !trade_vld) |=> (imb == ($past(imb) >>> DECAY)));

  p_buy_adds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (trade_vld && trade_buy && !tick) |=> (imb == $past(imb) + $past(qty_x)));
endmodule

// File: rtl/fvq_refresh.sv
module fvq_refresh #(
  parameter int PERIOD = 1024
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (PERIOD > 2) ? $clog2(PERIOD) : 1;
  logic [CW-1:0] cnt, cnt_nx;

  always_comb begin
    tick   = (cnt == CW'(PERIOD - 1));
    cnt_nx = tick ? '0 : cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_nx;
  end

  p_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (cnt == '0));
endmodule

// File: rtl/fvq_quote_gen.sv
module fvq_quote_gen
  import fvq_pkg::*;
#(
  parameter int LEVELS    = 4,
  parameter int PW        = 16,
  parameter int QW        = 8,
  parameter int POSW      = 12,
  parameter int KW        = 4,
  parameter int IW        = 16,
  parameter int OFI_SHIFT = 2,
  parameter int DECAY     = 1,
  parameter int TICK_LOG2 = 2,
  parameter int REFRESH   = 1024,
  localparam int DW       = $clog2(LEVELS) + 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   book_sync,
  input  logic [LEVELS*PW-1:0]   bid_px_i,
  input  logic [LEVELS*QW-1:0]   bid_sz_i,
  input  logic [LEVELS*PW-1:0]   ask_px_i,
  input  logic [LEVELS*QW-1:0]   ask_sz_i,
  input  logic [DW-1:0]          depth_cfg,
  input  logic                   trade_vld,
  input  logic                   trade_buy,
  input  logic [QW-1:0]          trade_qty,
  input  logic signed [POSW-1:0] net_pos,
  input  logic [KW-1:0]          skew_k,
  input  logic [PW-1:0]          spread_cfg,
  input  logic [QW-1:0]          size_cfg,
  input  logic [IW-1:0]          flow_thr,
  output logic                   quote_req,
  output logic                   quote_live,
  output logic [PW-1:0]          bid_px_o,
  output logic [PW-1:0]          ask_px_o,
  output logic [QW-1:0]          bid_qty_o,
  output logic [QW-1:0]          ask_qty_o
);
  localparam int FW = PW + IW + POSW + KW;
  localparam logic signed [FW-1:0] TMASK = FW'((1 << TICK_LOG2) - 1);
  localparam logic signed [FW-1:0] PMAXF = {{(FW-PW){1'b0}}, {PW{1'b1}}};

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_q;
  logic       rst_sync;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_sync = rst_q[1];

  logic [PW-1:0]        mid;
  logic                 top_ok, tick;
  logic signed [IW-1:0] imb;

  fvq_depth_mid #(.LEVELS(LEVELS), .PW(PW), .QW(QW), .DW(DW)) u_mid (
    .bid_px(bid_px_i), .bid_sz(bid_sz_i), .ask_px(ask_px_i), .ask_sz(ask_sz_i),
    .depth(depth_cfg), .mid(mid), .top_ok(top_ok)
  );

  fvq_refresh #(.PERIOD(REFRESH)) u_tmr (
    .clk(clk), .rst_n(rst_sync), .tick(tick)
  );

  fvq_flow #(.QW(QW), .IW(IW), .DECAY(DECAY)) u_flow (
    .clk(clk), .rst_n(rst_sync), .tick(tick), .trade_vld(trade_vld),
    .trade_buy(trade_buy), .trade_qty(trade_qty), .imb(imb)
  );

  function automatic logic [PW-1:0] clamp_px(input logic signed [FW-1:0] v);
    if (v < 0)          return '0;
    else if (v > PMAXF) return {PW{1'b1}};
    else                return v[PW-1:0];
  endfunction

  // fair value and candidate quote
  logic signed [FW-1:0] mid_x, imb_x, pos_x, k_x, spr_x, fv, bid_r, ask_r;
  logic signed [IW:0]   imb_w, thr_w;
  side_e                side;
  logic [PW-1:0]        bid_c, ask_c;
  logic [QW-1:0]        bq_c, aq_c;
  logic                 valid;

  always_comb begin
    mid_x = {{(FW-PW){1'b0}}, mid};
    imb_x = {{(FW-IW){imb[IW-1]}}, imb};
    pos_x = {{(FW-POSW){net_pos[POSW-1]}}, net_pos};
    k_x   = {{(FW-KW){1'b0}}, skew_k};
    spr_x = {{(FW-PW){1'b0}}, spread_cfg};
    fv    = mid_x + (imb_x >>> OFI_SHIFT) - (pos_x * k_x);
    bid_r = (fv - (spr_x >>> 1)) & ~TMASK;
    ask_r = (fv + (spr_x >>> 1) + TMASK) & ~TMASK;
    bid_c = clamp_px(bid_r);
    ask_c = clamp_px(ask_r);

    imb_w = {imb[IW-1], imb};
    thr_w = {1'b0, flow_thr};
    if (imb_w > thr_w)       side = SIDE_BID;
    else if (imb_w < -thr_w) side = SIDE_ASK;
    else                     side = SIDE_BOTH;
    bq_c  = (side == SIDE_ASK) ? '0 : size_cfg;
    aq_c  = (side == SIDE_BID) ? '0 : size_cfg;
    valid = book_sync & top_ok;
  end

  // quote registers: next state
  logic          live_q, req_q, live_nx, req_nx, chg;
  logic [PW-1:0] bid_q, ask_q, bid_nx, ask_nx;
  logic [QW-1:0] bq_q, aq_q, bq_nx, aq_nx;

  always_comb begin
    chg     = !live_q || (bid_c != bid_q) || (ask_c != ask_q) ||
              (bq_c != bq_q) || (aq_c != aq_q);
    live_nx = valid;
    req_nx  = valid && (chg || tick);
    bid_nx  = valid ? bid_c : bid_q;
    ask_nx  = valid ? ask_c : ask_q;
    bq_nx   = valid ? bq_c  : '0;
    aq_nx   = valid ? aq_c  : '0;
  end

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) begin
      live_q <= 1'b0;
      req_q  <= 1'b0;
      bid_q  <= '0;
      ask_q  <= '0;
      bq_q   <= '0;
      aq_q   <= '0;
    end else begin
      live_q <= live_nx;
      req_q  <= req_nx;
      bid_q  <= bid_nx;
      ask_q  <= ask_nx;
      bq_q   <= bq_nx;
      aq_q   <= aq_nx;
    end
  end

  assign quote_req  = req_q;
  assign quote_live = live_q;
  assign bid_px_o   = bid_q;
  assign ask_px_o   = ask_q;
  assign bid_qty_o  = bq_q;
  assign ask_qty_o  = aq_q;

  p_req_live_r8: assert property (@(posedge clk) disable iff (!rst_sync)
    quote_req |-> quote_live);

  p_quiet_r8: assert property (@(posedge clk) disable iff (!rst_sync)
    !book_sync |=> (!quote_live && !quote_req && bid_qty_o == '0 && ask_qty_o == '0));

  p_change_req_r9: assert property (@(posedge clk) disable iff (!rst_sync)
    (quote_live && $past(quote_live) && (bid_px_o != $past(bid_px_o))) |-> quote_req);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_sync)
    (!quote_live && $past(!quote_live)) |-> $stable(bid_px_o));
endmodule

// File: tb/fvq_quote_gen_test.sv
module fvq_quote_gen_test;
  localparam int REF = 16;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n;
  logic        book_sync;
  logic [63:0] bid_px_i, ask_px_i;
  logic [31:0] bid_sz_i, ask_sz_i;
  logic [2:0]  depth_cfg;
  logic        trade_vld, trade_buy;
  logic [7:0]  trade_qty;
  logic signed [11:0] net_pos;
  logic [3:0]  skew_k;
  logic [15:0] spread_cfg;
  logic [7:0]  size_cfg;
  logic [15:0] flow_thr;
  logic        quote_req, quote_live;
  logic [15:0] bid_px_o, ask_px_o;
  logic [7:0]  bid_qty_o, ask_qty_o;

  int bpx[4], bsz[4], apx[4], asz[4];

  always_comb begin
    for (int i = 0; i < 4; i++) begin
      bid_px_i[i*16 +: 16] = 16'(bpx[i]);
      ask_px_i[i*16 +: 16] = 16'(apx[i]);
      bid_sz_i[i*8 +: 8]   = 8'(bsz[i]);
      ask_sz_i[i*8 +: 8]   = 8'(asz[i]);
    end
  end

  fvq_quote_gen #(.LEVELS(4), .PW(16), .QW(8), .POSW(12), .KW(4), .IW(16),
                  .OFI_SHIFT(2), .DECAY(1), .TICK_LOG2(2), .REFRESH(REF)) uut (
    .clk(clk), .rst_n(rst_n), .book_sync(book_sync),
    .bid_px_i(bid_px_i), .bid_sz_i(bid_sz_i), .ask_px_i(ask_px_i), .ask_sz_i(ask_sz_i),
    .depth_cfg(depth_cfg), .trade_vld(trade_vld), .trade_buy(trade_buy),
    .trade_qty(trade_qty), .net_pos(net_pos), .skew_k(skew_k),
    .spread_cfg(spread_cfg), .size_cfg(size_cfg), .flow_thr(flow_thr),
    .quote_req(quote_req), .quote_live(quote_live), .bid_px_o(bid_px_o),
    .ask_px_o(ask_px_o), .bid_qty_o(bid_qty_o), .ask_qty_o(ask_qty_o)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // ---------------- reference model from the requirements ----------------
  int  edge_n = 0, ph = 0;
  bit  ph_ok = 0;
  int  m_imb = 0;
  int  e_bid = 0, e_ask = 0, e_bq = 0, e_aq = 0;
  bit  e_live = 0, e_req = 0;
  int  t_fv, t_half, t_cb, t_ca, t_cbq, t_caq, t_d;
  bit  t_tk, t_v;

  function automatic int ref_mid(int d);
    int dc, num, den;
    dc = (d == 0) ? 1 : ((d > 4) ? 4 : d);
    num = 0; den = 0;
    for (int i = 0; i < dc; i++) begin
      num += bpx[i]*bsz[i] + apx[i]*asz[i];
      den += bsz[i] + asz[i];
    end
    return (den == 0) ? 0 : num / den;
  endfunction

  function automatic int clampp(int v);
    return (v < 0) ? 0 : ((v > 65535) ? 65535 : v);
  endfunction

  always @(posedge clk) begin
    t_tk   = ph_ok && (((edge_n - ph) % REF) == 0);
    t_fv   = ref_mid(int'(depth_cfg)) + (m_imb >>> 2) - int'(net_pos) * int'(skew_k);
    t_half = int'(spread_cfg) >> 1;
    t_cb   = clampp((t_fv - t_half) & ~3);
    t_ca   = clampp((t_fv + t_half + 3) & ~3);
    t_cbq  = int'(size_cfg);
    t_caq  = int'(size_cfg);
    if (m_imb > int'(flow_thr))       t_caq = 0;
    else if (m_imb < -int'(flow_thr)) t_cbq = 0;
    t_v = book_sync && (bsz[0] != 0) && (asz[0] != 0);
    e_req  <= t_v && (!e_live || t_cb != e_bid || t_ca != e_ask ||
                      t_cbq != e_bq || t_caq != e_aq || t_tk);
    e_live <= t_v;
    if (t_v) begin
      e_bid <= t_cb; e_ask <= t_ca;
    end
    e_bq <= t_v ? t_cbq : 0;
    e_aq <= t_v ? t_caq : 0;
    t_d = trade_vld ? (trade_buy ? int'(trade_qty) : -int'(trade_qty)) : 0;
    m_imb  <= (t_tk ? (m_imb >>> 1) : m_imb) + t_d;
    edge_n <= edge_n + 1;
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check_quote(string tag);
    chk(tag, "bid_px", int'(bid_px_o), e_bid);
    chk(tag, "ask_px", int'(ask_px_o), e_ask);
    chk(tag, "bid_qty", int'(bid_qty_o), e_bq);
    chk(tag, "ask_qty", int'(ask_qty_o), e_aq);
    chk(tag, "live", int'(quote_live), int'(e_live));
    if (ph_ok) chk(tag, "req", int'(quote_req), int'(e_req));
  endtask

  task automatic set_pattern(int p);
    for (int i = 0; i < 4; i++) begin
      bpx[i] = 1000 + 13*p - 4*i;
      apx[i] = 1003 + 13*p + 5*i + (p % 3);
      bsz[i] = (i == 0) ? (1 + (p % 7)) : ((p*3 + i*5) % 9);
      asz[i] = (i == 0) ? (2 + (p % 5)) : ((p*7 + i*2) % 11);
    end
  endtask

  task automatic trade(bit buy, int q);
    trade_vld = 1'b1; trade_buy = buy; trade_qty = 8'(q);
    @(negedge clk);
    trade_vld = 1'b0;
  endtask

  initial begin
    int cnt, old_bid;
    rst_n = 1'b0; book_sync = 1'b0; depth_cfg = 3'd1;
    trade_vld = 1'b0; trade_buy = 1'b0; trade_qty = '0;
    net_pos = '0; skew_k = '0; spread_cfg = 16'd8; size_cfg = 8'd5; flow_thr = 16'd1000;
    set_pattern(0);
    step(4);
    // R1: reset state
    chk("R1", "req", int'(quote_req), 0);
    chk("R1", "live", int'(quote_live), 0);
    chk("R1", "bid_px", int'(bid_px_o), 0);
    chk("R1", "ask_px", int'(ask_px_o), 0);
    chk("R1", "bid_qty", int'(bid_qty_o), 0);
    chk("R1", "ask_qty", int'(ask_qty_o), 0);

    rst_n = 1'b1; book_sync = 1'b1;
    step(40);
    for (int i = 0; i < 40 && !ph_ok; i++) begin
      step(1);
      if (quote_req) begin ph = edge_n - 1; ph_ok = 1; end
    end
    chk("R10", "refresh pulse found", int'(ph_ok), 1);
    step(1);
    check_quote("R2");

    // R2: depth x book pattern sweep (depth 0 and 5 exercise the clamp)
    for (int d = 0; d < 6; d++)
      for (int p = 0; p < 6; p++) begin
        depth_cfg = 3'(d); set_pattern(p);
        step(1);
        check_quote("R2");
      end

    // R5: inventory skew sweep
    depth_cfg = 3'd2; set_pattern(2);
    for (int a = 0; a < 5; a++)
      for (int b = 0; b < 4; b++) begin
        int pv[5] = '{-50, -1, 0, 1, 37};
        int kv[4] = '{0, 1, 3, 15};
        net_pos = 12'(pv[a]); skew_k = 4'(kv[b]);
        step(1);
        check_quote("R5");
      end
    net_pos = '0; skew_k = '0;

    // R6: spread and tick rounding sweep over several mid offsets
    for (int p = 0; p < 4; p++)
      for (int s = 0; s < 12; s++) begin
        set_pattern(p); spread_cfg = 16'(s); size_cfg = 8'(s + 1);
        step(1);
        check_quote("R6");
      end
    spread_cfg = 16'd8; size_cfg = 8'd5;

    // R11: outputs only move at the next edge
    step(3);
    old_bid = int'(bid_px_o);
    set_pattern(5);
    chk("R11", "bid before edge", int'(bid_px_o), old_bid);
    step(1);
    check_quote("R11");

    // R3: trades of both sides
    trade(1'b1, 40); check_quote("R3"); step(1); check_quote("R3");
    trade(1'b0, 25); check_quote("R3"); step(1); check_quote("R3");
    trade(1'b0, 90); step(1); check_quote("R3");
    step(60);
    check_quote("R3");

    // R4 and R9: trade on the same edge as a refresh tick
    for (int rep = 0; rep < 3; rep++) begin
      while (((edge_n - ph) % REF) != 0) @(negedge clk);
      trade(1'b1, 200 - 50*rep);
      check_quote("R4");
      step(1);
      check_quote("R4");
      step(1);
      check_quote("R9");
    end
    step(200);
    check_quote("R4");

    // R10: steady quote, one pulse per period
    cnt = 0;
    for (int i = 0; i < 4*REF; i++) begin
      step(1);
      if (quote_req) cnt++;
    end
    chk("R10", "pulses in 4 periods", cnt, 4);

    // R7: one-sided quoting
    flow_thr = 16'd20;
    trade(1'b1, 100); step(1);
    chk("R7", "ask_qty under buy flow", int'(ask_qty_o), 0);
    check_quote("R7");
    trade(1'b0, 250); step(1);
    chk("R7", "bid_qty under sell flow", int'(bid_qty_o), 0);
    check_quote("R7");
    for (int i = 0; i < 40; i++) begin
      step(1);
      check_quote("R7");
    end
    flow_thr = 16'd1000;
    step(2);

    // R8: suppression
    old_bid = int'(bid_px_o);
    book_sync = 1'b0; set_pattern(3);
    for (int i = 0; i < 20; i++) begin
      step(1);
      chk("R8", "live", int'(quote_live), 0);
      chk("R8", "req", int'(quote_req), 0);
      chk("R8", "bid_qty", int'(bid_qty_o), 0);
      chk("R8", "bid hold", int'(bid_px_o), old_bid);
    end
    book_sync = 1'b1; asz[0] = 0;
    step(1);
    chk("R8", "live empty ask", int'(quote_live), 0);
    chk("R8", "ask_qty empty ask", int'(ask_qty_o), 0);
    asz[0] = 4;
    step(1);
    chk("R9", "req on becoming live", int'(quote_req), 1);
    check_quote("R9");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule